// File: doc/BRIEF.md
# Microcontroller Power-Mode Controller

This block sets the reduced-power state of a small 8-bit microcontroller. Software writes a 4-bit power-control register through a simple write port. From that register and from a set of exit events, the block produces three synchronous clock enables. The CPU enable gates the core. The peripheral enable gates the timers, serial ports, PWM and converter. The oscillator-run enable qualifies the oscillator. All logic runs on one free-running clock that stands for the oscillator, so the design contains no gated clocks.

Two low-power states exist. Idle stops only the CPU and ends on any enabled interrupt. Power-down stops everything, including the oscillator. Power-down can end through an enabled external wake line. A wake event first restarts the oscillator, and the clocks then stay off for a fixed settle count. Power-down can also end through the reset pin. On that path the clocks return as soon as the pin is released, with no settle count.

A long-enough reset pulse, or an internal timer-overflow reset pulse, clears the register and returns the block to run. Two bits of the register are general flags for software. They never change the mode.

Top module: `pwr_mode_ctl`

## Requirements
- R1: The register `pcon` is 4 bits wide. Bit 0 requests idle, bit 1 requests power-down, and bits 3:2 are software flags. A write with `wr_en` high loads `wr_data` into `pcon`, and the new value reads back on the following cycle. Power-on reset (`por_n` low) clears `pcon` and sets `mode` to run.
- R2: `mode` encodes the state as 0 for run, 1 for idle, 2 for power-down and 3 for wake-settling. In run, `cpu_ce`, `per_ce` and `osc_run` are all 1 and `strobe_park` is 0.
- R3: A write with bit 0 set and bit 1 clear puts the block in idle on the next cycle. In idle, `cpu_ce`=0 while `per_ce`=1 and `osc_run`=1.
- R4: A write with bit 1 set puts the block in power-down on the next cycle, whatever bit 0 holds. In power-down, `cpu_ce`=0, `per_ce`=0, `strobe_park`=1, and `osc_run`=0 unless `rst_pin` is high.
- R5: In idle, `irq_pend` high returns the block to run on the next cycle and clears `pcon` bit 0.
- R6: `rst_pin` is accepted only when it is sampled high on 24 consecutive clock edges. On the 24th such edge, `pcon` is cleared, and an idle or settling state goes to run. A pulse of 23 edges has no effect.
- R7: A one-cycle `tmr_rst` pulse clears `pcon` and sets run on the next cycle.
- R8: In power-down, an external wake line `wake_line[i]` with `wake_en[i]` set passes through a two-flop synchronizer. `mode` becomes 3 on the third clock edge after the line rises. A line whose enable is clear has no effect.
- R9: The block stays in state 3 for exactly 1536 cycles. It then returns to run with bits 1:0 of `pcon` cleared. `osc_run`=1 and `strobe_park`=1 while settling, and both `cpu_ce` and `per_ce` stay 0.
- R10: In power-down, an accepted `rst_pin` keeps the state at power-down while the pin stays high. The block goes to run on the first edge at which the pin is sampled low, without entering state 3.
- R11: The flag bits 3:2 hold their value across every mode change. They change only through a write or a reset.
- R12: Writes are ignored outside run. `irq_pend` is ignored in power-down and while settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Register write strobe from the CPU |
| wr_data | input | 4 | Register write data |
| pcon | output | 4 | Power-control register contents |
| irq_pend | input | 1 | Some enabled interrupt is pending |
| tmr_rst | input | 1 | Internal timer-overflow reset pulse |
| rst_pin | input | 1 | External reset pin, active high |
| wake_line | input | 7 | Asynchronous external wake lines 2 to 8 |
| wake_en | input | 7 | Enables for the wake lines |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator-run enable |
| strobe_park | output | 1 | Holds the external address and program strobes low |
| mode | output | 2 | Current state: 0 run, 1 idle, 2 power-down, 3 settling |

## Verification
A wrong state in this block shows up at the `mode` and clock-enable outputs on the very next cycle. The bench therefore compares them one cycle after each write, interrupt or reset. The settle counter is the one piece of state that stays hidden for a long time. An off-by-one error there appears only when the block leaves state 3, so the bench counts every settling cycle. It also checks the synchronizer latency and the reset-filter boundary exactly, at 23 and at 24 edges.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int RST_CYC    = 24,
  parameter int SETTLE_CYC = 1536,
  parameter int NWAKE      = 7
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_data,
  output logic [3:0]       pcon,
  input  logic             irq_pend,
  input  logic             tmr_rst,
  input  logic             rst_pin,
  input  logic [NWAKE-1:0] wake_line,
  input  logic [NWAKE-1:0] wake_en,
  output logic             cpu_ce,
  output logic             per_ce,
  output logic             osc_run,
  output logic             strobe_park,
  output logic [1:0]       mode
);

  localparam int RW = $clog2(RST_CYC);
  localparam int SW = $clog2(SETTLE_CYC);
  localparam logic [RW-1:0] RST_LAST = RW'(RST_CYC - 1);
  localparam logic [SW-1:0] SET_LAST = SW'(SETTLE_CYC - 1);

  localparam logic [1:0] M_RUN  = 2'd0;
  localparam logic [1:0] M_IDLE = 2'd1;
  localparam logic [1:0] M_PD   = 2'd2;
  localparam logic [1:0] M_SET  = 2'd3;

  logic [NWAKE-1:0] wk_a, wk_b;
  logic [RW-1:0]    rst_cnt;
  logic             rst_armed;
  logic [SW-1:0]    set_cnt;

  wire rst_hit = rst_pin && (rst_cnt == RST_LAST);
  wire wake_hit = |(wk_b & wake_en);

  assign cpu_ce      = (mode == M_RUN);
  assign per_ce      = (mode == M_RUN) || (mode == M_IDLE);
  assign osc_run     = (mode != M_PD) || rst_pin;
  assign strobe_park = (mode == M_PD) || (mode == M_SET);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wk_a      <= '0;
      wk_b      <= '0;
      rst_cnt   <= '0;
      rst_armed <= 1'b0;
      set_cnt   <= '0;
      pcon      <= 4'h0;
      mode      <= M_RUN;
    end else begin
      wk_a <= wake_line;
      wk_b <= wk_a;

      if (!rst_pin)
        rst_cnt <= '0;
      else if (rst_cnt != RST_LAST)
        rst_cnt <= rst_cnt + 1'b1;
      rst_armed <= rst_pin && (rst_armed || rst_hit);

      if (tmr_rst || rst_hit) begin
        pcon    <= 4'h0;
        set_cnt <= '0;
        mode    <= (rst_hit && !tmr_rst && mode == M_PD) ? M_PD : M_RUN;
      end else if (mode == M_PD && rst_armed && !rst_pin) begin
        mode <= M_RUN;
      end else begin
        unique case (mode)
          M_RUN: if (wr_en) begin
            pcon <= wr_data;
            if (wr_data[1])      mode <= M_PD;
            else if (wr_data[0]) mode <= M_IDLE;
          end
          M_IDLE: if (irq_pend) begin
            pcon[0] <= 1'b0;
            mode    <= M_RUN;
          end
          M_PD: if (wake_hit) begin
            set_cnt <= '0;
            mode    <= M_SET;
          end
          M_SET: if (set_cnt == SET_LAST) begin
            pcon[1:0] <= 2'b00;
            set_cnt   <= '0;
            mode      <= M_RUN;
          end else begin
            set_cnt <= set_cnt + 1'b1;
          end
          default: mode <= M_RUN;
        endcase
      end
    end
  end

  assert_settle_from_pd_R9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mode == M_SET) |-> $past(mode) == M_PD);

  assert_settle_exit_run_R9: assert property (@(posedge clk) disable iff (!por_n)
    ($past(mode) == M_SET && mode != M_SET) |-> (mode == M_RUN && pcon[1:0] == 2'b00));

  assert_idle_irq_exit_R5: assert property (@(posedge clk) disable iff (!por_n)
    (mode == M_IDLE && irq_pend && !tmr_rst && !rst_pin) |=> (mode == M_RUN && !pcon[0]));

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
    (!(wr_en && mode == M_RUN) && !tmr_rst && !rst_hit) |=> $stable(pcon[3:2]));

  assert_reset_clears_R6: assert property (@(posedge clk) disable iff (!por_n)
    rst_hit |=> pcon == 4'h0);

  assert_no_write_outside_run_R12: assert property (@(posedge clk) disable iff (!por_n)
    (mode != M_RUN && !tmr_rst && !rst_pin && !rst_armed) |=> $stable(pcon[3:2]));

  assert_pd_leave_paths_R10: assert property (@(posedge clk) disable iff (!por_n)
    ($past(mode) == M_PD && mode == M_RUN) |-> ($past(rst_armed) || $past(tmr_rst)));

endmodule

// File: tb/pwr_mode_ctl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctl_test;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic [3:0] pcon;
  logic irq_pend = 1'b0, tmr_rst = 1'b0, rst_pin = 1'b0;
  logic [6:0] wake_line = '0, wake_en = '0;
  logic cpu_ce, per_ce, osc_run, strobe_park;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwr_mode_ctl uut (.clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
    .pcon(pcon), .irq_pend(irq_pend), .tmr_rst(tmr_rst), .rst_pin(rst_pin),
    .wake_line(wake_line), .wake_en(wake_en), .cpu_ce(cpu_ce), .per_ce(per_ce),
    .osc_run(osc_run), .strobe_park(strobe_park), .mode(mode));

  function automatic logic [1:0] exp_mode(input logic [3:0] d);
    return d[1] ? 2'd2 : (d[0] ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [3:0] exp_ce(input logic [1:0] m, input logic pin);
    case (m)
      2'd0: return 4'b1110;
      2'd1: return 4'b0110;
      2'd2: return {2'b00, pin, 1'b1};
      default: return 4'b0011;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic chk_ce(input string req);
    logic [3:0] e;
    e = exp_ce(mode, rst_pin);
    chk({cpu_ce, per_ce, osc_run, strobe_park} == e, req,
        {cpu_ce, per_ce, osc_run, strobe_park}, e);
  endtask

  task automatic settle_count(input logic [3:0] f);
    int n = 0;
    while (mode == 2'd3 && n < 5000) begin
      if (n == 5) chk_ce("R9 settling enables");
      n++;
      step(1);
    end
    chk(n == 1536, "R9 settle length", n, 1536);
    chk(mode == 2'd0 && pcon == {f[3:2], 2'b00}, "R9 exit state", {mode, pcon}, {2'd0, f[3:2], 2'b00});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    step(3);
    chk(pcon == 4'h0 && mode == 2'd0, "R1 reset state", {mode, pcon}, 0);
    por_n = 1'b1;
    step(1);
    chk_ce("R2 run enables");

    wr(4'b1100);
    chk(pcon == 4'hC && mode == 2'd0, "R1 flag write", {mode, pcon}, 6'h0C);

    wr(4'b1101);
    chk(mode == 2'd1, "R3 idle entry", mode, 1);
    chk_ce("R3 idle enables");
    wr(4'b0010);
    chk(pcon == 4'hD && mode == 2'd1, "R12 write ignored in idle", pcon, 4'hD);
    irq_pend = 1'b1; step(1); irq_pend = 1'b0;
    chk(mode == 2'd0 && pcon == 4'hC, "R5 idle irq exit", {mode, pcon}, 6'h0C);

    wr(4'b0111);
    chk(mode == 2'd2, "R4 pd precedence", mode, 2);
    chk_ce("R4 pd enables");
    irq_pend = 1'b1; wake_line = 7'b0000100; wake_en = 7'b0000011;
    step(6);
    chk(mode == 2'd2, "R8 disabled line and R12 irq ignored", mode, 2);
    irq_pend = 1'b0; wake_line = 7'b0000001;
    step(2);
    chk(mode == 2'd2, "R8 sync latency", mode, 2);
    step(1);
    chk(mode == 2'd3, "R8 settle entry", mode, 3);
    wake_line = '0;
    settle_count(4'b0100);
    wake_en = '0;

    wr(4'b1001);
    rst_pin = 1'b1; step(23); rst_pin = 1'b0; step(1);
    chk(mode == 2'd1 && pcon == 4'h9, "R6 23-edge pulse ignored", {mode, pcon}, 6'h19);
    rst_pin = 1'b1; step(24);
    chk(mode == 2'd0 && pcon == 4'h0, "R6 24-edge reset", {mode, pcon}, 0);
    rst_pin = 1'b0; step(1);

    wr(4'b1001);
    tmr_rst = 1'b1; step(1); tmr_rst = 1'b0;
    chk(mode == 2'd0 && pcon == 4'h0, "R7 timer reset", {mode, pcon}, 0);

    wr(4'b1010);
    rst_pin = 1'b1; step(1);
    chk_ce("R4 osc follows pin");
    step(23);
    chk(mode == 2'd2 && pcon == 4'h0 && !cpu_ce, "R10 held in pd", {mode, pcon}, 6'h20);
    step(4);
    rst_pin = 1'b0; step(1);
    chk(mode == 2'd0, "R10 release to run", mode, 0);
    chk_ce("R10 run enables");

    wr(4'b0010);
    rst_pin = 1'b1; step(23); rst_pin = 1'b0; step(3);
    chk(mode == 2'd2, "R10 short pulse ignored in pd", mode, 2);
    tmr_rst = 1'b1; step(1); tmr_rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      logic [3:0] f;
      int sel;
      f = 4'($urandom) & 4'b1100;
      sel = $urandom % 3;
      if (sel == 0) begin
        wr(f);
        chk(mode == exp_mode(f) && pcon == f, "R1 random write", pcon, f);
      end else if (sel == 1) begin
        wr(f | 4'b0001);
        chk(mode == 2'd1, "R3 random idle", mode, 1);
        step($urandom % 8);
        chk(mode == 2'd1 && pcon[3:2] == f[3:2], "R11 idle hold", pcon, f | 4'b0001);
        irq_pend = 1'b1; step(1); irq_pend = 1'b0;
        chk(mode == 2'd0 && pcon == f, "R5 random irq exit", {mode, pcon}, f);
      end else begin
        int j;
        logic [3:0] d;
        j = $urandom % 7;
        d = f | 4'b0010 | 4'($urandom % 2);
        wr(d);
        chk(mode == 2'd2, "R4 random pd", mode, 2);
        wake_en = 7'($urandom) | (7'd1 << j);
        wake_line = 7'd1 << j;
        step(3);
        chk(mode == 2'd3, "R8 random wake", mode, 3);
        wake_line = '0;
        settle_count(f);
        chk(pcon[3:2] == f[3:2], "R11 flags kept", pcon, f);
        wake_en = '0;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule